// File: doc/BRIEF.md
# Vertical-Scan Raster Timing Generator

This block produces all timing for a raster display whose beam sweeps vertically, from the bottom of the screen to the top. The picture data comes from a circulating shift memory. A fast system clock is divided down to a slot rate. In each slot one bit position of the current vertical trace is presented.

Every trace has two parts. A run of data slots comes first, followed by a short vertical retrace during which video is blanked and the memory holds still. Traces are counted as display lines. When the last line of the frame has finished, a horizontal retrace flag is raised for a fixed number of traces. During those traces the trace timing keeps running, but only every other memory shift pulse is let through. The circulating memory therefore keeps moving at half speed instead of stopping, and the bits it moves during this time are never shown.

The outputs are a one-cycle memory shift strobe, the vertical and horizontal sync flags, a combined blanking flag, the current line count and the position within the trace. Neighbouring logic can compare the line count against a stored line number to decide where to load new data. The block has no data stream of its own, so every pin is a plain control or status signal.

Top module: `raster_timing`

## Requirements
- R1: Each position slot lasts DIV clock cycles (10 by default). `bit_o` advances by one at the end of every slot, and the first slot after reset spans cycles 0 to DIV-1.
- R2: `bit_o` counts from 0 to BITS+VRET-1 and then returns to 0. Values below BITS are data slots and the rest are vertical retrace slots.
- R3: `vsync_o` is 1 exactly while `bit_o` is BITS or greater. `blank_o` is 1 whenever `vsync_o` or `hsync_o` is 1 and is 0 otherwise.
- R4: `mem_shift_o` is a one-cycle pulse in the last clock cycle of a data slot, and it is never 1 during a vertical retrace slot. Outside horizontal retrace, every data slot gives exactly one pulse (BITS pulses per trace).
- R5: `line_o` steps by one at the end of each trace, running from 0 up to LINES-1.
- R6: When the trace of line LINES-1 ends, `hsync_o` goes to 1 for HR traces. During that time `line_o` holds 0.
- R7: While `hsync_o` is 1, a pulse is issued only in data slots with an even position (0, 2, 4, ...). That gives BITS/2 pulses per trace and HR*BITS/2 pulses over the whole horizontal retrace (1024 with the default values).
- R8: After HR traces of horizontal retrace, `hsync_o` returns to 0 and a new frame starts at line 0, position 0.
- R9: While `rst_i` is high at a clock edge, all counters and flags clear. After release, the block starts again at line 0, position 0, with `mem_shift_o`, `vsync_o`, `hsync_o` and `blank_o` all at 0. This also holds when reset is applied in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mem_shift_o | output | 1 | One-cycle shift strobe for the circulating memory |
| vsync_o | output | 1 | Vertical retrace in progress |
| hsync_o | output | 1 | Horizontal retrace in progress (half-rate memory clock) |
| blank_o | output | 1 | Video blanked |
| line_o | output | LINE_W | Current vertical line count |
| bit_o | output | POS_W | Slot position within the current trace |

## Verification
The main copy of the bench uses a divide ratio of 4, 8 data slots, 4 retrace slots, 6 lines and 3 horizontal-retrace traces. With these values one frame lasts 432 cycles, so line wrap, entry into and exit from horizontal retrace, and the half-rate gating all occur twice within a short run and can be counted exactly. A second copy is built with the default values (divide by ten, 128 data slots, 280 lines). It checks the reset state and confirms that slots last ten cycles, with the first shift strobe in cycle 9.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Width that holds the values 0 .. n-1, never smaller than one bit.
  function automatic int cwidth(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/raster_prescaler.sv
module raster_prescaler #(
  parameter int DIV = 10
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o,   // last cycle of a slot
  output logic pre_o     // cycle before the last one
);
  import raster_pkg::*;
  localparam int DIV_W = cwidth(DIV);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)        cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (int'(cnt_q) == DIV - 1);
  assign pre_o  = (int'(cnt_q) == DIV - 2);

  assert_div_range_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(cnt_q) < DIV);

endmodule

// File: rtl/raster_trace.sv
module raster_trace #(
  parameter int BITS  = 128,
  parameter int VRET  = 16,
  parameter int POS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  output logic [POS_W-1:0] pos_o,
  output logic             vr_o,
  output logic             vr_nxt_o,
  output logic             active_o,
  output logic             eot_o
);
  localparam int TRACE_LEN = BITS + VRET;

  logic [POS_W-1:0] pos_q, pos_nxt;
  logic             vr_q;
  logic             last_slot;

  assign last_slot = (int'(pos_q) == TRACE_LEN - 1);

  always_comb begin
    pos_nxt = pos_q;
    if (tick_i) pos_nxt = last_slot ? '0 : pos_q + 1'b1;
  end

  assign vr_nxt_o = (int'(pos_nxt) >= BITS);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pos_q <= '0;
      vr_q  <= 1'b0;
    end else begin
      pos_q <= pos_nxt;
      vr_q  <= vr_nxt_o;
    end
  end

  assign pos_o    = pos_q;
  assign vr_o     = vr_q;
  assign active_o = (int'(pos_q) < BITS);
  assign eot_o    = tick_i & last_slot;

  assert_pos_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(pos_q) < TRACE_LEN);
  assert_vr_flag_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    vr_q == (int'(pos_q) >= BITS));

endmodule

// File: rtl/raster_frame.sv
module raster_frame #(
  parameter int LINES  = 280,
  parameter int HR     = 16,
  parameter int LINE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              eot_i,
  output logic [LINE_W-1:0] line_o,
  output logic              hs_o,
  output logic              hs_nxt_o
);
  import raster_pkg::*;
  localparam int HR_W = cwidth(HR);

  logic [LINE_W-1:0] line_q, line_nxt;
  logic [HR_W-1:0]   hr_q, hr_nxt;
  logic              hs_q;

  always_comb begin
    line_nxt = line_q;
    hs_nxt_o = hs_q;
    hr_nxt   = hr_q;
    if (eot_i) begin
      if (!hs_q) begin
        if (int'(line_q) == LINES - 1) begin
          line_nxt = '0;
          hs_nxt_o = 1'b1;
          hr_nxt   = '0;
        end else begin
          line_nxt = line_q + 1'b1;
        end
      end else if (int'(hr_q) == HR - 1) begin
        hs_nxt_o = 1'b0;
        hr_nxt   = '0;
      end else begin
        hr_nxt = hr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      line_q <= '0;
      hs_q   <= 1'b0;
      hr_q   <= '0;
    end else begin
      line_q <= line_nxt;
      hs_q   <= hs_nxt_o;
      hr_q   <= hr_nxt;
    end
  end

  assign line_o = line_q;
  assign hs_o   = hs_q;

  assert_line_range_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(line_q) < LINES);
  assert_hs_line_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    hs_q |-> (line_q == '0));
  assert_hr_range_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(hr_q) < HR);

endmodule

// File: rtl/raster_shift_gate.sv
module raster_shift_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic pre_i,
  input  logic active_i,
  input  logic hs_i,
  output logic shift_o
);
  logic phase_q;
  logic shift_q;

  // During horizontal retrace the phase toggles on every data slot;
  // only slots seen with phase 0 produce a strobe.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= 1'b0;
      shift_q <= 1'b0;
    end else begin
      shift_q <= pre_i & active_i & (~hs_i | ~phase_q);
      if (tick_i) begin
        if (!hs_i)         phase_q <= 1'b0;
        else if (active_i) phase_q <= ~phase_q;
      end
    end
  end

  assign shift_o = shift_q;

  assert_phase_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !hs_i |=> (!phase_q || hs_i));

endmodule

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int DIV    = 10,
  parameter int BITS   = 128,
  parameter int VRET   = 16,
  parameter int LINES  = 280,
  parameter int HR     = 16,
  parameter int LINE_W = 9,
  localparam int POS_W = raster_pkg::cwidth(BITS + VRET)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  output logic              mem_shift_o,
  output logic              vsync_o,
  output logic              hsync_o,
  output logic              blank_o,
  output logic [LINE_W-1:0] line_o,
  output logic [POS_W-1:0]  bit_o
);
  logic tick, pre, active, eot;
  logic vr, vr_nxt, hs, hs_nxt;
  logic blank_q;

  raster_prescaler #(.DIV(DIV)) u_pre (
    .clk_i(clk_i), .rst_i(rst_i), .tick_o(tick), .pre_o(pre)
  );

  raster_trace #(.BITS(BITS), .VRET(VRET), .POS_W(POS_W)) u_trace (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick), .pos_o(bit_o),
    .vr_o(vr), .vr_nxt_o(vr_nxt), .active_o(active), .eot_o(eot)
  );

  raster_frame #(.LINES(LINES), .HR(HR), .LINE_W(LINE_W)) u_frame (
    .clk_i(clk_i), .rst_i(rst_i), .eot_i(eot), .line_o(line_o),
    .hs_o(hs), .hs_nxt_o(hs_nxt)
  );

  raster_shift_gate u_gate (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick), .pre_i(pre),
    .active_i(active), .hs_i(hs), .shift_o(mem_shift_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) blank_q <= 1'b0;
    else       blank_q <= vr_nxt | hs_nxt;
  end

  assign vsync_o = vr;
  assign hsync_o = hs;
  assign blank_o = blank_q;

  assert_shift_not_retrace_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    mem_shift_o |-> !vsync_o);
  assert_blank_merge_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    blank_o == (vsync_o | hsync_o));
  assert_shift_at_slot_end_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    mem_shift_o |-> tick);

endmodule

// File: tb/test_raster_timing.sv
module test_raster_timing;
  localparam int DIV = 4, BITS = 8, VRET = 4, LINES = 6, HR = 3, LINE_W = 9;
  localparam int TLEN = BITS + VRET;
  localparam int FRAME_CYC = (LINES + HR) * TLEN * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic             sh, vs, hs, bl;
  logic [LINE_W-1:0] ln;
  logic [3:0]        bt;
  logic             d_sh, d_vs, d_hs, d_bl;
  logic [8:0]        d_ln;
  logic [7:0]        d_bt;

  raster_timing #(.DIV(DIV), .BITS(BITS), .VRET(VRET), .LINES(LINES),
                  .HR(HR), .LINE_W(LINE_W)) i_raster_timing (
    .clk_i(clk), .rst_i(rst), .mem_shift_o(sh), .vsync_o(vs), .hsync_o(hs),
    .blank_o(bl), .line_o(ln), .bit_o(bt)
  );

  raster_timing i_raster_timing_dflt (
    .clk_i(clk), .rst_i(rst), .mem_shift_o(d_sh), .vsync_o(d_vs), .hsync_o(d_hs),
    .blank_o(d_bl), .line_o(d_ln), .bit_o(d_bt)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] cyc;
    logic [8:0]  line;
    logic [3:0]  pos;
    logic        hs;
    logic        vs;
    logic        sh;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{cyc:16'd0,   line:9'd0, pos:4'd0,  hs:1'b0, vs:1'b0, sh:1'b0},
    '{cyc:16'd3,   line:9'd0, pos:4'd0,  hs:1'b0, vs:1'b0, sh:1'b1},
    '{cyc:16'd5,   line:9'd0, pos:4'd1,  hs:1'b0, vs:1'b0, sh:1'b0},
    '{cyc:16'd33,  line:9'd0, pos:4'd8,  hs:1'b0, vs:1'b1, sh:1'b0},
    '{cyc:16'd48,  line:9'd1, pos:4'd0,  hs:1'b0, vs:1'b0, sh:1'b0},
    '{cyc:16'd287, line:9'd5, pos:4'd11, hs:1'b0, vs:1'b1, sh:1'b0},
    '{cyc:16'd288, line:9'd0, pos:4'd0,  hs:1'b1, vs:1'b0, sh:1'b0},
    '{cyc:16'd291, line:9'd0, pos:4'd0,  hs:1'b1, vs:1'b0, sh:1'b1},
    '{cyc:16'd295, line:9'd0, pos:4'd1,  hs:1'b1, vs:1'b0, sh:1'b0},
    '{cyc:16'd299, line:9'd0, pos:4'd2,  hs:1'b1, vs:1'b0, sh:1'b1},
    '{cyc:16'd335, line:9'd0, pos:4'd11, hs:1'b1, vs:1'b1, sh:1'b0},
    '{cyc:16'd432, line:9'd0, pos:4'd0,  hs:1'b0, vs:1'b0, sh:1'b0}
  };

  int cyc;

  task automatic release_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int nsh, nsh_hr;
    // Reset state (R9), both copies
    repeat (2) @(negedge clk);
    chk("R9", "reset line", int'(ln), 0);
    chk("R9", "reset bit", int'(bt), 0);
    chk("R9", "reset shift", int'(sh), 0);
    chk("R9", "reset blank", int'(bl), 0);
    chk("R9", "dflt reset hsync", int'(d_hs), 0);

    // Vector table walk (R1 R2 R3 R4 R5 R6 R7 R8)
    release_reset();
    for (int i = 0; i < NV; i++) begin
      while (cyc < int'(TBL[i].cyc)) step();
      chk("R5", $sformatf("line @%0d", cyc), int'(ln), int'(TBL[i].line));
      chk("R2", $sformatf("bit @%0d", cyc), int'(bt), int'(TBL[i].pos));
      chk("R6", $sformatf("hsync @%0d", cyc), int'(hs), int'(TBL[i].hs));
      chk("R3", $sformatf("vsync @%0d", cyc), int'(vs), int'(TBL[i].vs));
      chk("R7", $sformatf("shift @%0d", cyc), int'(sh), int'(TBL[i].sh));
    end

    // Cycle-accurate model over two frames after a fresh reset
    release_reset();
    nsh = 0; nsh_hr = 0;
    for (int c = 0; c < 2 * FRAME_CYC + 40; c++) begin
      int slot, pos, tf, eline;
      bit ehs, evs, esh;
      slot = c / DIV;
      pos  = slot % TLEN;
      tf   = (slot / TLEN) % (LINES + HR);
      ehs  = (tf >= LINES);
      eline = ehs ? 0 : tf;
      evs  = (pos >= BITS);
      esh  = (c % DIV == DIV - 1) && (pos < BITS) && (!ehs || (pos % 2 == 0));
      if (int'(ln) != eline) chk("R5", $sformatf("model line @%0d", c), int'(ln), eline);
      if (int'(bt) != pos)   chk("R1", $sformatf("model bit @%0d", c), int'(bt), pos);
      if (hs != ehs)         chk("R8", $sformatf("model hsync @%0d", c), int'(hs), int'(ehs));
      if (vs != evs)         chk("R3", $sformatf("model vsync @%0d", c), int'(vs), int'(evs));
      if (bl != (evs | ehs)) chk("R3", $sformatf("model blank @%0d", c), int'(bl), int'(evs | ehs));
      if (sh != esh)         chk("R4", $sformatf("model shift @%0d", c), int'(sh), int'(esh));
      checks++;
      if (c < FRAME_CYC && sh) begin
        nsh++;
        if (hs) nsh_hr++;
      end
      // Default copy: ten-cycle slots, first strobe in cycle 9 (R1)
      if (c == 8)  chk("R1", "dflt shift c8", int'(d_sh), 0);
      if (c == 9)  begin
        chk("R1", "dflt shift c9", int'(d_sh), 1);
        chk("R1", "dflt bit c9", int'(d_bt), 0);
      end
      if (c == 10) chk("R1", "dflt bit c10", int'(d_bt), 1);
      step();
    end
    chk("R4", "shifts per frame", nsh, LINES * BITS + HR * BITS / 2);
    chk("R7", "shifts in hretrace", nsh_hr, HR * BITS / 2);

    // Mid-frame reset (R9)
    while (hs == 1'b0) step();
    repeat (7) step();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R9", "mid reset line", int'(ln), 0);
    chk("R9", "mid reset hsync", int'(hs), 0);
    chk("R9", "mid reset shift", int'(sh), 0);
    rst = 1'b0;
    cyc = 0;
    chk("R9", "restart bit", int'(bt), 0);
    repeat (3) step();
    chk("R9", "restart first shift", int'(sh), 1);
    repeat (45) step();
    chk("R9", "restart line1", int'(ln), 1);
    chk("R9", "restart hsync low", int'(hs), 0);

    finish_run();
  end
endmodule